// File: doc/BRIEF.md
# Cable Word Time-Division Merger

This block takes several wide parallel cable buses that all change at the rate of a slow bunch clock, and sends them one after another over a single output bus. The output runs on a fast clock that is synchronous to the slow clock and exactly as many times faster as there are cables (four by default). Each cable word is 40 bits wide and carries two towers. A tower is a 10-bit electromagnetic energy and a 10-bit hadronic energy. The block does not interpret these fields and passes them through unchanged.

On every slow rising edge all cable buses are latched together into holding registers. A small counter in the fast domain then steps the multiplexer select across the cables, starting with cable 0. Each output word carries a binary index that names the cable it came from. The counter is realigned to the slow clock every period, so the first word after a capture is always cable 0. The output stays silent (all zero) during reset and until the first capture after reset has been taken.

Top module: `cable_tdm_merge`

## Requirements
- R1: On each rising edge of `slow_clk`, all cable inputs are latched together, and the words sent during the following slow period come only from that capture.
- R2: Cable k occupies bits [40k+39 : 40k] of `cables_i`, and its output word equals those 40 bits unchanged, including the tower energy fields.
- R3: `cable_idx_o` is the binary number of the cable whose word is on `word_o` in the same cycle, counting 0, 1, 2, 3 and then back to 0.
- R4: The word for cable 0 appears on the first `fast_clk` rising edge after a `slow_clk` rising edge (one fast cycle later). Cables 1, 2 and 3 follow on the next three fast edges.
- R5: The word for the last cable, which is registered on the same edge as the next slow capture, still comes from the previous capture. Input changes made partway through a slow period do not show up until the period after the next slow edge.
- R6: `rst` is synchronous and active high. From the first fast edge that sees it high, `word_o` and `cable_idx_o` are zero for as long as it stays high.
- R7: After `rst` falls, the outputs stay zero until the first slow capture taken after release. One fast cycle after that capture, the output starts with cable 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slow_clk | input | 1 | Bunch-rate clock; cable inputs are latched on its rising edge |
| fast_clk | input | 1 | Output clock, synchronous, LANES times the slow rate, rising edges coincident with slow ones |
| rst | input | 1 | Synchronous active-high reset from the downstream receiver |
| cables_i | input | LANES*WORD_W (160) | All cable buses side by side, cable k at bits [WORD_W*k +: WORD_W] |
| word_o | output | WORD_W (40) | Registered output word, one cable per fast cycle |
| cable_idx_o | output | IDX_W (2) | Registered index of the cable carried by word_o |

## Verification
If the select counter loses its phase, the index sequence stops starting at 0 one fast cycle after each slow edge. That shows up within a single slow period as a word carrying the wrong cable's bits under the wrong index. A fault where the fast side reads the holding registers at the wrong moment shows up one fast cycle after a slow edge, as the last cable's word carrying the new capture instead of the old one. A fault in clearing after reset, or in holding the output silent before the first capture, shows up within the first slow period after the edge of `rst`, as a nonzero word or index.

// File: rtl/tdm_merge_pkg.sv
package tdm_merge_pkg;

  localparam int unsigned LANES_DEF  = 4;
  localparam int unsigned WORD_W_DEF = 40;

  // Width of an index able to name n lanes (at least one bit).
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tdm_capture.sv
// Slow-domain holding registers: all lanes latched together each slow edge,
// plus a toggle flag that flips on every capture so the fast side can see it.
module tdm_capture
  import tdm_merge_pkg::*;
#(
  parameter int unsigned LANES  = LANES_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF
) (
  input  logic                           slow_clk,
  input  logic                           rst,
  input  logic [LANES*WORD_W-1:0]        cables_i,
  output logic [LANES-1:0][WORD_W-1:0]   held_o,
  output logic                           tog_o
);

  logic [LANES-1:0][WORD_W-1:0] held_q;
  logic                         tog_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge slow_clk) begin
      if (rst) held_q[g] <= '0;
      else     held_q[g] <= cables_i[g*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge slow_clk) begin
    if (rst) tog_q <= 1'b0;
    else     tog_q <= ~tog_q;
  end

  assign held_o = held_q;
  assign tog_o  = tog_q;

endmodule

// File: rtl/tdm_phase.sv
// Fast-domain select sequencer: detects each slow capture through the toggle
// flag and restarts the lane counter at 0 on the following fast edge.
module tdm_phase
  import tdm_merge_pkg::*;
#(
  parameter int unsigned LANES = LANES_DEF,
  localparam int unsigned IDX_W = idx_bits(LANES)
) (
  input  logic             fast_clk,
  input  logic             rst,
  input  logic             tog_i,
  output logic [IDX_W-1:0] sel_o,
  output logic             valid_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

  logic             tog_seen_q;
  logic             primed_q;
  logic [IDX_W-1:0] cnt_q;
  logic             pulse;
  logic [IDX_W-1:0] sel;

  assign pulse = tog_i ^ tog_seen_q;
  assign sel   = pulse ? '0 : cnt_q;

  always_ff @(posedge fast_clk) begin
    if (rst) begin
      tog_seen_q <= 1'b0;
      primed_q   <= 1'b0;
      cnt_q      <= '0;
    end else begin
      tog_seen_q <= tog_i;
      primed_q   <= primed_q | pulse;
      cnt_q      <= (sel == LAST) ? '0 : sel + 1'b1;
    end
  end

  assign sel_o   = sel;
  assign valid_o = primed_q | pulse;

  // R4: once running, each new capture lands exactly where the counter wrapped
  p_phase_aligned_r4: assert property (@(posedge fast_clk) disable iff (rst)
    (pulse && primed_q) |-> (cnt_q == '0));

endmodule

// File: rtl/tdm_outreg.sv
// Output stage: picks the selected lane from the holding registers and
// registers it with its index; silent while in reset or not yet primed.
module tdm_outreg
  import tdm_merge_pkg::*;
#(
  parameter int unsigned LANES  = LANES_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF,
  localparam int unsigned IDX_W = idx_bits(LANES)
) (
  input  logic                         fast_clk,
  input  logic                         rst,
  input  logic [LANES-1:0][WORD_W-1:0] held_i,
  input  logic [IDX_W-1:0]             sel_i,
  input  logic                         valid_i,
  output logic [WORD_W-1:0]            word_o,
  output logic [IDX_W-1:0]             idx_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic              vld_q;

  always_ff @(posedge fast_clk) begin
    if (rst || !valid_i) begin
      word_q <= '0;
      idx_q  <= '0;
    end else begin
      word_q <= held_i[sel_i];
      idx_q  <= sel_i;
    end
  end

  always_ff @(posedge fast_clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= valid_i;
  end

  assign word_o = word_q;
  assign idx_o  = idx_q;

  // R6: a reset cycle leaves the outputs cleared
  p_clear_in_reset_r6: assert property (@(posedge fast_clk)
    rst |=> (word_q == '0 && idx_q == '0));

  // R4: indices advance by one per fast cycle within a period
  p_idx_step_r4: assert property (@(posedge fast_clk) disable iff (rst)
    (vld_q && idx_q != LAST) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)));

  // R3: after the last lane the index returns to lane 0
  p_idx_wrap_r3: assert property (@(posedge fast_clk) disable iff (rst)
    (vld_q && idx_q == LAST) |=> (idx_q == '0));

endmodule

// File: rtl/cable_tdm_merge.sv
module cable_tdm_merge
  import tdm_merge_pkg::*;
#(
  parameter int unsigned LANES  = LANES_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF,
  localparam int unsigned IDX_W = idx_bits(LANES)
) (
  input  logic                    slow_clk,
  input  logic                    fast_clk,
  input  logic                    rst,
  input  logic [LANES*WORD_W-1:0] cables_i,
  output logic [WORD_W-1:0]       word_o,
  output logic [IDX_W-1:0]        cable_idx_o
);

  logic [LANES-1:0][WORD_W-1:0] held;
  logic                         tog;
  logic [IDX_W-1:0]             sel;
  logic                         valid;

  tdm_capture #(.LANES(LANES), .WORD_W(WORD_W)) u_capture (
    .slow_clk (slow_clk),
    .rst      (rst),
    .cables_i (cables_i),
    .held_o   (held),
    .tog_o    (tog)
  );

  tdm_phase #(.LANES(LANES)) u_phase (
    .fast_clk (fast_clk),
    .rst      (rst),
    .tog_i    (tog),
    .sel_o    (sel),
    .valid_o  (valid)
  );

  tdm_outreg #(.LANES(LANES), .WORD_W(WORD_W)) u_outreg (
    .fast_clk (fast_clk),
    .rst      (rst),
    .held_i   (held),
    .sel_i    (sel),
    .valid_i  (valid),
    .word_o   (word_o),
    .idx_o    (cable_idx_o)
  );

endmodule

// File: tb/tb_cable_tdm_merge.sv
`timescale 1ns/1ps
module tb_cable_tdm_merge;

  localparam int LANES  = 4;
  localparam int WORD_W = 40;
  localparam int NVEC   = 6;

  logic                    slow_clk = 1'b0;
  logic                    fast_clk = 1'b0;
  logic                    rst      = 1'b1;
  logic [LANES*WORD_W-1:0] cables   = '0;
  logic [WORD_W-1:0]       word;
  logic [1:0]              idx;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  // Stimulus table: each row is one full set of cable words (cable 3 leftmost).
  // Expected word k is the row's slice k with index k.
  localparam logic [LANES*WORD_W-1:0] VEC [NVEC] = '{
    {40'h3333333333, 40'h2222222222, 40'h1111111111, 40'h0000000000},
    {40'hFFFFFFFFFF, 40'h0000000000, 40'hFFFFFFFFFF, 40'h0000000000},
    {40'h123456789A, 40'hA5A5A5A5A5, 40'h5A5A5A5A5A, 40'hFEDCBA9876},
    {40'h003FF003FF, 40'hFFC00FFC00, 40'h0000100001, 40'h8000080000},
    {40'h0000000001, 40'h8000000000, 40'h0F0F0F0F0F, 40'hF0F0F0F0F0},
    {40'hDEADBEEF01, 40'hC0FFEE0042, 40'h7777777777, 40'h0102030405}
  };

  cable_tdm_merge dut (
    .slow_clk    (slow_clk),
    .fast_clk    (fast_clk),
    .rst         (rst),
    .cables_i    (cables),
    .word_o      (word),
    .cable_idx_o (idx)
  );

  // 250 MHz fast clock; slow clock at a quarter rate, rising with fast.
  initial begin
    int ph = 0;
    forever begin
      #2;
      fast_clk = 1'b1;
      if (ph == 0) slow_clk = 1'b1;
      else if (ph == 2) slow_clk = 1'b0;
      ph = (ph + 1) % 4;
      #2;
      fast_clk = 1'b0;
    end
  end

  always @(posedge fast_clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_run  = n_run + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not complete, actual cycles=%0d expected<=20000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [WORD_W-1:0] exp_w,
                       input logic [1:0] exp_i);
    n_run = n_run + 1;
    if (word !== exp_w || idx !== exp_i) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual word=%h idx=%0d expected word=%h idx=%0d",
               req, word, idx, exp_w, exp_i);
    end
  endtask

  function automatic logic [WORD_W-1:0] slice(input logic [LANES*WORD_W-1:0] v,
                                              input int k);
    return v[k*WORD_W +: WORD_W];
  endfunction

  // After a slow edge, check the four words on the following fast edges.
  task automatic check_period(input string req, input logic [LANES*WORD_W-1:0] v);
    for (int k = 0; k < LANES; k++) begin
      @(posedge fast_clk); #1;
      check(req, slice(v, k), 2'(k));
    end
  endtask

  initial begin
    // R6: outputs zero while reset is held, even with nonzero inputs
    cables = VEC[2];
    repeat (10) @(posedge fast_clk);
    #1;
    check("R6 reset hold", '0, 2'd0);

    // R7: release between slow edges; silent until first capture after release
    @(posedge slow_clk); #1;
    @(negedge fast_clk);
    rst = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      @(posedge fast_clk); #1;
      check("R7 silent before first capture", '0, 2'd0);
    end
    // that last fast edge coincided with the first capture after release
    check_period("R7 first capture starts at cable 0", VEC[2]);

    // R1 R2 R3 R4: table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge slow_clk); #1;
      cables = VEC[i];
      @(posedge slow_clk); #1;
      check_period("R2 R3 R4 table word", VEC[i]);
    end

    // R5: change inputs mid-period; last words must come from the older capture
    @(negedge slow_clk); #1;
    cables = VEC[0];
    @(posedge slow_clk); #1;
    @(posedge fast_clk); #1;
    check("R5 cable 0 before change", slice(VEC[0], 0), 2'd0);
    cables = VEC[5];
    @(posedge fast_clk); #1;
    check("R5 cable 1 after input change", slice(VEC[0], 1), 2'd1);
    @(posedge fast_clk); #1;
    check("R5 cable 2 after input change", slice(VEC[0], 2), 2'd2);
    @(posedge fast_clk); #1;
    check("R5 cable 3 on capture edge", slice(VEC[0], 3), 2'd3);
    // R1: the next period carries the new capture from its first word
    check_period("R1 next capture", VEC[5]);

    // R5: back-to-back changes every slow period
    cables = VEC[3];
    @(posedge slow_clk); #1;
    cables = VEC[4];
    check_period("R5 back-to-back first", VEC[3]);
    check_period("R5 back-to-back second", VEC[4]);

    // R6: mid-run reset clears on the next fast edge
    @(posedge slow_clk); #1;
    @(posedge fast_clk); #1;
    rst = 1'b1;
    @(posedge fast_clk); #1;
    check("R6 mid-run reset clears", '0, 2'd0);
    repeat (9) @(posedge fast_clk);
    #1;
    check("R6 held through reset", '0, 2'd0);

    // R7: release right after a slow edge, then resume with cable 0
    cables = VEC[1];
    @(posedge slow_clk); #1;
    rst = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      @(posedge fast_clk); #1;
      check("R7 silent after second release", '0, 2'd0);
    end
    check_period("R7 resume at cable 0", VEC[1]);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule